// File: doc/BRIEF.md
# Comma Alignment Sequencer

This block finds the 10-bit character boundary on a set of deserialized receive lanes once the per-lane input delays have been calibrated. It is started by a single-cycle `start` pulse. It then works through a series of alignment attempts. In each attempt it sets a word-slip control for the downstream decoders and sends two bitslip pulses to the deserializers. Two pulses are needed because every line bit is captured twice by the 2x oversampled input. It waits for the lanes to settle, clears its internal sticky comma detector, waits again, and then samples the detector.

The detector watches the decoded byte stream and its control flag from lane 0. It latches when it sees either comma control character. The first five attempts of a round keep word-slip low and the last five drive it high. A round therefore sweeps the character phase across two clock cycles. If a whole round fails, the block waits for a retry interval and begins a new round.

On success the block raises `rx_ready` and stops issuing bitslips. It also reports on `align_attempt` which attempt of the round succeeded, for debugging.

Top module: `comma_align_seq`

## Requirements
- R1: While `rst` is high, and after it falls, `bitslip`, `wordslip`, `rx_ready` and `comma_flag` are low and `align_attempt` is 0.
- R2: A `start` pulse is acted on only in the idle state and begins attempt 1. A `start` pulse while ready issues no bitslip and leaves `align_attempt` unchanged.
- R3: Each attempt issues exactly two `bitslip` pulses. Each pulse lasts one cycle, and the two are separated by at least one low cycle.
- R4: `wordslip` is 0 for attempts 1 to 5 and 1 for attempts 6 to 10 (MAX_ATTEMPTS=10). It takes its value before the attempt's first bitslip and keeps it through both pulses.
- R5: `comma_flag` is set by a decoded byte of 0x3C or 0xBC with `dec_ctrl`=1. Any other byte, or either of those bytes with `dec_ctrl`=0, does not set it. Once set, it stays high until the sequencer clears it.
- R6: In each attempt, the detector is cleared after both bitslips and the settle delay, and it is sampled SAMPLE_CYC cycles later. A comma seen before that clear does not count for the attempt.
- R7: A round has at most MAX_ATTEMPTS attempts. After the last one fails, no bitslip occurs for at least RETRY_CYC cycles, and the next round restarts at attempt 1.
- R8: On success, `rx_ready` rises and stays high until reset, no further bitslip is issued, and `align_attempt` holds the number (1 to MAX_ATTEMPTS) of the successful attempt within its round.
- R9: `rx_ready` is high only while `comma_flag` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins alignment after delay calibration |
| dec_byte | input | 8 | Decoded byte from lane 0 decoder |
| dec_ctrl | input | 1 | Control-character flag for `dec_byte` |
| bitslip | output | 1 | Single-cycle bitslip pulse to the lane deserializers |
| wordslip | output | 1 | Half-character phase shift control to the decoders |
| rx_ready | output | 1 | Alignment done, receive path usable |
| comma_flag | output | 1 | Sticky comma detector state |
| align_attempt | output | ATTEMPT_W (4) | Attempt number that succeeded, 0 before success |

## Verification
The bench builds the block with SETTLE_CYC=3, SAMPLE_CYC=6 and RETRY_CYC=40, and keeps MAX_ATTEMPTS at 10. The short waits let a full failing round, the retry gap and a success in the second round all fit in a few hundred cycles. Keeping the full 10 attempts means the word-slip switch between attempts 5 and 6 is exercised, and so is a success that occurs after the round count wraps. A stand-in decoder emits a comma only after a chosen number of bitslips. This pins the expected attempt number exactly, and it also allows a comma to be shown before the first clear.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_SETUP,
    S_SLIP_A,
    S_GAP,
    S_SLIP_B,
    S_SETTLE,
    S_CLEAR,
    S_SAMPLE,
    S_CHECK,
    S_RETRY,
    S_READY
  } align_state_e;
endpackage

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/comma_detect.sv
module comma_detect #(
  parameter int                    N_CODES = 2,
  parameter logic [N_CODES*8-1:0]  CODES   = {8'hBC, 8'h3C}
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [7:0] byte_in,
  input  logic       ctrl_in,
  output logic       flag
);
  logic [N_CODES-1:0] match;

  for (genvar g = 0; g < N_CODES; g++) begin : g_code
    assign match[g] = ctrl_in && (byte_in == CODES[g*8 +: 8]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag <= 1'b0;
    end else if (|match) begin
      flag <= 1'b1;
    end
  end
endmodule

// File: rtl/comma_align_seq.sv
module comma_align_seq
  import comma_align_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 10,
  parameter int SETTLE_CYC   = 16,
  parameter int SAMPLE_CYC   = 1000,
  parameter int RETRY_CYC    = 100000,
  localparam int ATTEMPT_W   = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [7:0]           dec_byte,
  input  logic                 dec_ctrl,
  output logic                 bitslip,
  output logic                 wordslip,
  output logic                 rx_ready,
  output logic                 comma_flag,
  output logic [ATTEMPT_W-1:0] align_attempt
);
  localparam int HALF    = MAX_ATTEMPTS / 2;
  localparam int DUR_A   = (SETTLE_CYC > SAMPLE_CYC) ? SETTLE_CYC : SAMPLE_CYC;
  localparam int DUR_MAX = (DUR_A > RETRY_CYC) ? DUR_A : RETRY_CYC;
  localparam int TIMER_W = $clog2(DUR_MAX + 1);

  align_state_e         state_q, state_d;
  logic [ATTEMPT_W-1:0] attempt_q, attempt_d;
  logic                 tmr_load, tmr_zero;
  logic [TIMER_W-1:0]   tmr_val;
  logic                 det_clr;
  logic                 bitslip_q, wordslip_q, ready_q;
  logic [ATTEMPT_W-1:0] found_q;

  wait_timer #(.W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign det_clr = (state_q == S_CLEAR);

  comma_detect u_det (
    .clk     (clk),
    .rst     (rst),
    .clr     (det_clr),
    .byte_in (dec_byte),
    .ctrl_in (dec_ctrl),
    .flag    (comma_flag)
  );

  always_comb begin
    state_d   = state_q;
    attempt_d = attempt_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    case (state_q)
      S_IDLE: if (start) begin
        state_d   = S_SETUP;
        attempt_d = ATTEMPT_W'(1);
      end
      S_SETUP:  state_d = S_SLIP_A;
      S_SLIP_A: state_d = S_GAP;
      S_GAP:    state_d = S_SLIP_B;
      S_SLIP_B: begin
        state_d  = S_SETTLE;
        tmr_load = 1'b1;
        tmr_val  = TIMER_W'(SETTLE_CYC - 1);
      end
      S_SETTLE: if (tmr_zero) state_d = S_CLEAR;
      S_CLEAR: begin
        state_d  = S_SAMPLE;
        tmr_load = 1'b1;
        tmr_val  = TIMER_W'(SAMPLE_CYC - 1);
      end
      S_SAMPLE: if (tmr_zero) state_d = S_CHECK;
      S_CHECK: begin
        if (comma_flag) begin
          state_d = S_READY;
        end else if (attempt_q == ATTEMPT_W'(MAX_ATTEMPTS)) begin
          state_d  = S_RETRY;
          tmr_load = 1'b1;
          tmr_val  = TIMER_W'(RETRY_CYC - 1);
        end else begin
          state_d   = S_SETUP;
          attempt_d = attempt_q + 1'b1;
        end
      end
      S_RETRY: if (tmr_zero) begin
        state_d   = S_SETUP;
        attempt_d = ATTEMPT_W'(1);
      end
      S_READY:  state_d = S_READY;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      attempt_q  <= '0;
      bitslip_q  <= 1'b0;
      wordslip_q <= 1'b0;
      ready_q    <= 1'b0;
      found_q    <= '0;
    end else begin
      state_q   <= state_d;
      attempt_q <= attempt_d;
      bitslip_q <= (state_d == S_SLIP_A) || (state_d == S_SLIP_B);
      if (state_d == S_SETUP) begin
        wordslip_q <= (attempt_d > ATTEMPT_W'(HALF));
      end
      if (state_q == S_CHECK && state_d == S_READY) begin
        ready_q <= 1'b1;
        found_q <= attempt_q;
      end
    end
  end

  assign bitslip       = bitslip_q;
  assign wordslip      = wordslip_q;
  assign rx_ready      = ready_q;
  assign align_attempt = found_q;
endmodule

// File: rtl/comma_align_seq_chk.sv
module comma_align_seq_chk #(
  parameter int MAX_ATTEMPTS = 10,
  parameter int ATTEMPT_W    = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [7:0]           dec_byte,
  input logic                 dec_ctrl,
  input logic                 bitslip,
  input logic                 wordslip,
  input logic                 rx_ready,
  input logic                 comma_flag,
  input logic                 det_clr,
  input logic [ATTEMPT_W-1:0] align_attempt
);
  assert_slip_single_R3: assert property (@(posedge clk) disable iff (rst)
    bitslip |=> !bitslip);

  assert_ws_stable_R4: assert property (@(posedge clk) disable iff (rst)
    bitslip |-> $stable(wordslip));

  assert_comma_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (comma_flag && !det_clr) |=> comma_flag);

  assert_comma_set_R5: assert property (@(posedge clk) disable iff (rst)
    (dec_ctrl && (dec_byte == 8'h3C || dec_byte == 8'hBC) && !det_clr) |=> comma_flag);

  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    rx_ready |=> rx_ready);

  assert_no_slip_ready_R8: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> !bitslip);

  assert_attempt_range_R8: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (align_attempt >= 1 && align_attempt <= ATTEMPT_W'(MAX_ATTEMPTS)));

  assert_ready_comma_R9: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> comma_flag);
endmodule

bind comma_align_seq comma_align_seq_chk #(
  .MAX_ATTEMPTS (MAX_ATTEMPTS),
  .ATTEMPT_W    (ATTEMPT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .dec_byte      (dec_byte),
  .dec_ctrl      (dec_ctrl),
  .bitslip       (bitslip),
  .wordslip      (wordslip),
  .rx_ready      (rx_ready),
  .comma_flag    (comma_flag),
  .det_clr       (det_clr),
  .align_attempt (align_attempt)
);

// File: tb/comma_align_seq_tb.sv
module comma_align_seq_tb;
  localparam int MAXA   = 10;
  localparam int SETTLE = 3;
  localparam int SAMPLE = 6;
  localparam int RETRY  = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] dec_byte = 8'h00;
  logic       dec_ctrl = 1'b0;
  logic       bitslip, wordslip, rx_ready, comma_flag;
  logic [3:0] align_attempt;

  int checks = 0, failures = 0;
  int mon_checks = 0, mon_fail = 0;
  int cyc = 0, slips = 0, last_slip = -100;
  int target = 0;
  logic [7:0] comma_val = 8'hBC;
  logic [7:0] fill_byte = 8'h00;
  logic       fill_ctrl = 1'b0;

  always #2 clk = ~clk;

  comma_align_seq #(
    .MAX_ATTEMPTS (MAXA),
    .SETTLE_CYC   (SETTLE),
    .SAMPLE_CYC   (SAMPLE),
    .RETRY_CYC    (RETRY)
  ) u_dut (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .dec_byte      (dec_byte),
    .dec_ctrl      (dec_ctrl),
    .bitslip       (bitslip),
    .wordslip      (wordslip),
    .rx_ready      (rx_ready),
    .comma_flag    (comma_flag),
    .align_attempt (align_attempt)
  );

  // Monitor and stand-in decoder: comma appears once 2*target slips were seen
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      slips = 0;
      last_slip = -100;
    end else if (bitslip) begin
      int att;
      mon_checks++;
      if (cyc - last_slip < 2) begin
        mon_fail++;
        $display("FAIL R3 bitslip spacing act=%0d exp>=2", cyc - last_slip);
      end
      mon_checks++;
      if (rx_ready) begin
        mon_fail++;
        $display("FAIL R8 bitslip while ready act=1 exp=0");
      end
      slips++;
      att = ((slips - 1) / 2) % MAXA + 1;
      mon_checks++;
      if (wordslip !== (att > MAXA / 2)) begin
        mon_fail++;
        $display("FAIL R4 wordslip at attempt %0d act=%0b exp=%0b", att, wordslip, att > MAXA / 2);
      end
      if (slips > 1 && (slips - 1) % (2 * MAXA) == 0) begin
        mon_checks++;
        if (cyc - last_slip <= RETRY) begin
          mon_fail++;
          $display("FAIL R7 retry gap act=%0d exp>%0d", cyc - last_slip, RETRY);
        end
      end
      last_slip = cyc;
    end
    if (target != 0 && slips >= 2 * target) begin
      dec_byte = comma_val;
      dec_ctrl = 1'b1;
    end else begin
      dec_byte = fill_byte;
      dec_ctrl = fill_ctrl;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    target = 0;
    fill_byte = 8'h00;
    fill_ctrl = 1'b0;
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_ready(input int limit);
    for (int i = 0; i < limit && !rx_ready; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(bitslip == 0 && wordslip == 0, "R1 slip outputs after reset", {bitslip, wordslip}, 0);
    chk(rx_ready == 0 && comma_flag == 0, "R1 ready/flag after reset", {rx_ready, comma_flag}, 0);
    chk(align_attempt == 0, "R1 attempt after reset", align_attempt, 0);
    repeat (20) @(negedge clk);
    chk(slips == 0, "R2 no slip without start", slips, 0);
  endtask

  task automatic t_success(input int tgt, input logic [7:0] cv);
    do_reset();
    comma_val = cv;
    target = tgt;
    pulse_start();
    wait_ready(3000);
    chk(rx_ready == 1, "R8 ready after comma", rx_ready, 1);
    chk(align_attempt == (tgt - 1) % MAXA + 1, "R8 attempt number", align_attempt, (tgt - 1) % MAXA + 1);
    chk(slips == 2 * tgt, "R3 two slips per attempt", slips, 2 * tgt);
    chk(wordslip == (((tgt - 1) % MAXA + 1) > MAXA / 2), "R4 wordslip held", wordslip,
        ((tgt - 1) % MAXA + 1) > MAXA / 2);
    chk(comma_flag == 1, "R9 flag with ready", comma_flag, 1);
  endtask

  task automatic t_stale_comma();
    do_reset();
    fill_byte = 8'hBC;
    fill_ctrl = 1'b1;
    repeat (3) @(negedge clk);
    fill_ctrl = 1'b0;
    repeat (5) @(negedge clk);
    chk(comma_flag == 1, "R5 flag sticky after comma gone", comma_flag, 1);
    chk(rx_ready == 0, "R2 idle without start", rx_ready, 0);
    comma_val = 8'h3C;
    target = 4;
    pulse_start();
    wait_ready(3000);
    chk(align_attempt == 4, "R6 early comma not counted", align_attempt, 4);
  endtask

  task automatic t_wrong_codes();
    do_reset();
    fill_byte = 8'h3C;
    fill_ctrl = 1'b0;
    pulse_start();
    repeat (40) @(negedge clk);
    fill_byte = 8'h7C;
    fill_ctrl = 1'b1;
    repeat (60) @(negedge clk);
    chk(comma_flag == 0, "R5 non-comma bytes ignored", comma_flag, 0);
    chk(rx_ready == 0, "R9 no ready without comma", rx_ready, 0);
    chk(slips > 2, "R7 attempts continue", slips, 3);
  endtask

  task automatic t_start_ignored();
    int s0;
    t_success(2, 8'hBC);
    s0 = slips;
    pulse_start();
    repeat (60) @(negedge clk);
    chk(slips == s0, "R2 start ignored when ready", slips, s0);
    chk(align_attempt == 2, "R2 attempt unchanged", align_attempt, 2);
  endtask

  initial begin
    t_reset_state();
    t_success(2, 8'hBC);
    t_success(7, 8'h3C);
    t_success(10, 8'hBC);
    t_stale_comma();
    t_wrong_codes();
    t_success(MAXA + 3, 8'h3C);
    t_start_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fail);
    $finish;
  end
endmodule